// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block collects interrupt requests from two grouped event banks and from a set of direct events, and drives one active-high interrupt pin. Each bank keeps sticky status bits next to a matching enable register. The first bank also has a master enable. A bank's gated request sets a summary bit in a top-level status register. The top-level register also takes the direct events, and it has its own enable register.

The enabled OR of the top level goes to the pin through a clocked hold stage. A pin-enable bit in a configuration register controls this stage. While pin-enable is 1, the pin follows the top-level request one cycle later. While it is 0, the pin keeps its level, whatever software writes to the other registers. Software can use this to freeze the pin while it clears status, or to mask it without losing pending events. All registers are reached through a single-cycle read/write bus. Reads are combinational and writes are taken on the clock edge.

Top module: `irq_aggregator`

## Requirements
- R1: A bit in group A status (address 0, bits 5:0) or group B status (address 2, bits 10:0) is set by a 1 on its event input. It stays 1 until a write of 1 to that bit position at the same address clears it.
- R2: Group A's request is the OR of (status AND enable) over its 6 bits (enable at address 1, bits 5:0), ANDed with the master enable at bit 31 of address 1. A 1 sets top-level status bit 0 on the next edge. With the master enable at 0, group A never sets that bit.
- R3: Group B's request is the OR of (status AND enable) over its 11 bits (enable at address 3, bits 10:0). It has no master enable. A 1 sets top-level status bit 1 on the next edge.
- R4: Top-level status (address 4) holds bit 0 (group A summary), bit 1 (group B summary) and bits 9:2, which are set by the direct events 7:0. The top-level request is the OR of (status AND enable), with the enable at address 5, bits 9:0.
- R5: An event in the same cycle as a write-one-to-clear of its bit wins, so the bit stays 1. Writing 0 to a status bit has no effect.
- R6: A top-level summary bit cannot be cleared while its group's gated request is still 1. Once that request has fallen, it can be cleared.
- R7: While pin-enable (address 6, bit 0) is 1, the output `irq` equals the top-level request sampled on the previous edge.
- R8: While pin-enable is 0, `irq` holds its value, whatever is written to any status or enable register and whatever events arrive.
- R9: Synchronous reset clears all status bits, all enables, the master enable and pin-enable, and drives `irq` to 0.
- R10: Reads return the register at `bus_addr` with unused bits as 0. A read of address 1 shows the master enable at bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_a | input | 6 | Group A event pulses |
| evt_b | input | 11 | Group B event pulses |
| evt_t | input | 8 | Direct top-level event pulses (top bits 9:2) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt pin, active high |

## Verification
A wrong status bit shows on a read of its register in the next cycle. On the pin, a wrong group bit takes three edges to appear: the group status, then the top summary, then the hold stage. A wrong direct bit takes two. A hold stage that leaks while frozen shows as a change of `irq` during any pin-enable-low window in which status or enables change. A summary bit that clears too early shows as a top-level read of 0 while the group still has an enabled, pending event.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 3;
    localparam int GRP_A_W    = 6;
    localparam int GRP_B_W    = 11;
    localparam int TOP_W      = 10;
    localparam int SUM_A_BIT  = 0;
    localparam int SUM_B_BIT  = 1;
    localparam int DIRECT_LO  = 2;
    localparam int DIRECT_W   = TOP_W - DIRECT_LO;
    localparam int MASTER_BIT = 31;
    localparam int PIN_EN_BIT = 0;

    typedef enum logic [ADDR_W-1:0] {
        SEL_A_STAT = 3'd0,
        SEL_A_EN   = 3'd1,
        SEL_B_STAT = 3'd2,
        SEL_B_EN   = 3'd3,
        SEL_T_STAT = 3'd4,
        SEL_T_EN   = 3'd5,
        SEL_CFG    = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic logic hit(input bus_req_t req, input reg_sel_e s);
        return req.wr && (req.sel == s);
    endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_agg_pkg::*;
#(
    parameter int W          = 6,
    parameter bit HAS_MASTER = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      evt,
    input  logic              stat_wr,
    input  logic              en_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [W-1:0]      stat_o,
    output logic [W-1:0]      en_o,
    output logic              master_o,
    output logic              req_o
);

    logic [W-1:0] stat_q;
    logic [W-1:0] en_q;
    logic [W-1:0] clr_mask;

    assign clr_mask = stat_wr ? wdata[W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | evt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= wdata[W-1:0];
        end
    end

    generate
        if (HAS_MASTER) begin : g_master
            logic master_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    master_q <= 1'b0;
                end else if (en_wr) begin
                    master_q <= wdata[MASTER_BIT];
                end
            end
            assign master_o = master_q;
        end else begin : g_no_master
            assign master_o = 1'b1;
        end
    endgenerate

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign req_o  = (|(stat_q & en_q)) & master_o;

endmodule

// File: rtl/irq_out_latch.sv
module irq_out_latch (
    input  logic clk,
    input  logic rst,
    input  logic pin_en,
    input  logic req,
    output logic irq
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (pin_en) begin
            irq_q <= req;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [GRP_A_W-1:0]  evt_a,
    input  logic [GRP_B_W-1:0]  evt_b,
    input  logic [DIRECT_W-1:0] evt_t,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq
);

    bus_req_t           req;
    logic [GRP_A_W-1:0] stat_a, en_a;
    logic [GRP_B_W-1:0] stat_b, en_b;
    logic [TOP_W-1:0]   stat_t, en_t, evt_top;
    logic               master_a, master_b;
    logic               req_a, req_b, req_t, top_master;
    logic               pin_en;

    assign req.wr   = bus_wr;
    assign req.sel  = reg_sel_e'(bus_addr);
    assign req.data = bus_wdata;

    irq_status_bank #(.W(GRP_A_W), .HAS_MASTER(1'b1)) u_bank_a (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_a),
        .stat_wr  (hit(req, SEL_A_STAT)),
        .en_wr    (hit(req, SEL_A_EN)),
        .wdata    (req.data),
        .stat_o   (stat_a),
        .en_o     (en_a),
        .master_o (master_a),
        .req_o    (req_a)
    );

    irq_status_bank #(.W(GRP_B_W), .HAS_MASTER(1'b0)) u_bank_b (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_b),
        .stat_wr  (hit(req, SEL_B_STAT)),
        .en_wr    (hit(req, SEL_B_EN)),
        .wdata    (req.data),
        .stat_o   (stat_b),
        .en_o     (en_b),
        .master_o (master_b),
        .req_o    (req_b)
    );

    always_comb begin
        evt_top                               = '0;
        evt_top[SUM_A_BIT]                    = req_a;
        evt_top[SUM_B_BIT]                    = req_b;
        evt_top[TOP_W-1:DIRECT_LO]            = evt_t;
    end

    irq_status_bank #(.W(TOP_W), .HAS_MASTER(1'b0)) u_bank_t (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_top),
        .stat_wr  (hit(req, SEL_T_STAT)),
        .en_wr    (hit(req, SEL_T_EN)),
        .wdata    (req.data),
        .stat_o   (stat_t),
        .en_o     (en_t),
        .master_o (top_master),
        .req_o    (req_t)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_en <= 1'b0;
        end else if (hit(req, SEL_CFG)) begin
            pin_en <= req.data[PIN_EN_BIT];
        end
    end

    irq_out_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .pin_en (pin_en),
        .req    (req_t),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (req.sel)
            SEL_A_STAT: bus_rdata[GRP_A_W-1:0] = stat_a;
            SEL_A_EN: begin
                bus_rdata[GRP_A_W-1:0] = en_a;
                bus_rdata[MASTER_BIT]  = master_a;
            end
            SEL_B_STAT: bus_rdata[GRP_B_W-1:0] = stat_b;
            SEL_B_EN:   bus_rdata[GRP_B_W-1:0] = en_b;
            SEL_T_STAT: bus_rdata[TOP_W-1:0]   = stat_t;
            SEL_T_EN:   bus_rdata[TOP_W-1:0]   = en_t;
            SEL_CFG:    bus_rdata[PIN_EN_BIT]  = pin_en;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_agg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [GRP_A_W-1:0] evt_a,
    input logic [GRP_A_W-1:0] stat_a,
    input logic [GRP_A_W-1:0] en_a,
    input logic               master_a,
    input logic [TOP_W-1:0]   stat_t,
    input logic               req_t,
    input logic               pin_en,
    input logic               irq
);

    AST_IRQ_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !pin_en |=> $stable(irq)); // R8

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        pin_en |=> (irq == $past(req_t))); // R7

    AST_A_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == SEL_A_STAT) |=> ((stat_a & $past(stat_a)) == $past(stat_a))); // R1

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (evt_a != '0) |=> ((stat_a & $past(evt_a)) == $past(evt_a))); // R5

    AST_A_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        (master_a && |(stat_a & en_a)) |=> stat_t[SUM_A_BIT]); // R6

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> !irq); // R9

endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .evt_a    (evt_a),
    .stat_a   (stat_a),
    .en_a     (en_a),
    .master_a (master_a),
    .stat_t   (stat_t),
    .req_t    (req_t),
    .pin_en   (pin_en),
    .irq      (irq)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
    import irq_agg_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [GRP_A_W-1:0]  evt_a = '0;
    logic [GRP_B_W-1:0]  evt_b = '0;
    logic [DIRECT_W-1:0] evt_t = '0;
    logic                bus_wr = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [DATA_W-1:0]   bus_wdata = '0;
    logic [DATA_W-1:0]   bus_rdata;
    logic                irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator i_irq_aggregator (
        .clk       (clk),
        .rst       (rst),
        .evt_a     (evt_a),
        .evt_b     (evt_b),
        .evt_t     (evt_t),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'd0, irq} : bus_rdata;
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic pulse_a(input logic [GRP_A_W-1:0] m);
        evt_a = m; @(posedge clk); #1; evt_a = '0;
    endtask

    task automatic pulse_b(input logic [GRP_B_W-1:0] m);
        evt_b = m; @(posedge clk); #1; evt_b = '0;
    endtask

    task automatic pulse_t(input logic [DIRECT_W-1:0] m);
        evt_t = m; @(posedge clk); #1; evt_t = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R9 reset state
        chk_irq(1'b0, "R9 irq after reset");
        chk_rd(SEL_A_EN, 32'h0, "R9 group A enable after reset");
        chk_rd(SEL_CFG, 32'h0, "R9 pin enable after reset");

        wr(SEL_A_EN, 32'h8000_0003);
        wr(SEL_T_EN, 32'h3FF);
        wr(SEL_CFG, 32'h1);
        chk_rd(SEL_A_EN, 32'h8000_0003, "R10 master at bit 31");

        // R1 sticky set, enable gating of a disabled bit
        pulse_a(6'b000100);
        chk_rd(SEL_A_STAT, 32'h4, "R1 group A sticky");
        idle(3);
        chk_irq(1'b0, "R2 disabled bit gives no irq");
        chk_rd(SEL_T_STAT, 32'h0, "R2 no summary for disabled bit");

        // R2 enabled bit propagates
        pulse_a(6'b000001);
        idle(3);
        chk_rd(SEL_T_STAT, 32'h1, "R2 group A summary set");
        chk_irq(1'b1, "R7 irq asserted");
        chk_rd(SEL_A_STAT, 32'h5, "R1 both bits held");

        // R2 master enable off
        wr(SEL_A_EN, 32'h0000_0003);
        wr(SEL_T_STAT, 32'h1);
        idle(2);
        chk_rd(SEL_T_STAT, 32'h0, "R2 master off, summary clears");
        chk_irq(1'b0, "R7 irq follows cleared request");

        // R6 summary cannot clear while pending
        wr(SEL_A_EN, 32'h8000_0001);
        idle(1);
        wr(SEL_T_STAT, 32'h1);
        idle(1);
        chk_rd(SEL_T_STAT, 32'h1, "R6 summary held while pending");
        wr(SEL_A_STAT, 32'h3F);
        wr(SEL_T_STAT, 32'h1);
        idle(2);
        chk_rd(SEL_T_STAT, 32'h0, "R6 summary clears after group clear");
        chk_rd(SEL_A_STAT, 32'h0, "R1 write-one clears group A");
        chk_irq(1'b0, "R7 irq low after clear");

        // R3 group B
        wr(SEL_B_EN, 32'h400);
        pulse_b(11'h400);
        idle(3);
        chk_rd(SEL_T_STAT, 32'h2, "R3 group B summary");
        chk_irq(1'b1, "R3 irq from group B");
        pulse_b(11'h001);
        chk_rd(SEL_B_STAT, 32'h401, "R1 group B sticky");
        wr(SEL_B_STAT, 32'h7FF);
        wr(SEL_T_STAT, 32'h2);
        idle(2);
        chk_rd(SEL_T_STAT, 32'h0, "R3 group B summary cleared");
        chk_irq(1'b0, "R3 irq low");

        // R4 direct events
        pulse_t(8'h01);
        idle(2);
        chk_rd(SEL_T_STAT, 32'h4, "R4 direct event at bit 2");
        chk_irq(1'b1, "R4 irq from direct event");

        // R5 event wins over simultaneous clear
        evt_t = 8'h01;
        wr(SEL_T_STAT, 32'h4);
        evt_t = '0;
        chk_rd(SEL_T_STAT, 32'h4, "R5 event beats clear");
        wr(SEL_T_STAT, 32'h0);
        chk_rd(SEL_T_STAT, 32'h4, "R5 zero write no effect");

        // R4 top enable gating
        wr(SEL_T_EN, 32'h3FB);
        idle(2);
        chk_irq(1'b0, "R4 top enable masks bit 2");
        wr(SEL_T_EN, 32'h3FF);
        idle(2);
        chk_irq(1'b1, "R4 top enable restored");

        // R8 frozen while pin enable low
        wr(SEL_CFG, 32'h0);
        wr(SEL_T_STAT, 32'h3FF);
        idle(3);
        chk_irq(1'b1, "R8 irq held after clear");
        chk_rd(SEL_T_STAT, 32'h0, "R8 status cleared underneath");
        wr(SEL_CFG, 32'h1);
        idle(2);
        chk_irq(1'b0, "R7 irq follows after re-enable");
        wr(SEL_CFG, 32'h0);
        pulse_t(8'h02);
        idle(3);
        chk_irq(1'b0, "R8 new event does not reach pin");
        chk_rd(SEL_T_STAT, 32'h8, "R8 event still pending");

        // masking without losing status
        wr(SEL_CFG, 32'h1);
        idle(2);
        chk_irq(1'b1, "R7 pending event reaches pin");
        wr(SEL_T_EN, 32'h0);
        wr(SEL_CFG, 32'h0);
        idle(3);
        chk_irq(1'b0, "R8 masked and frozen low");
        chk_rd(SEL_T_STAT, 32'h8, "R8 status kept while masked");
        wr(SEL_T_EN, 32'h3FF);
        idle(2);
        chk_irq(1'b0, "R8 enable restore alone keeps pin");
        wr(SEL_CFG, 32'h1);
        idle(2);
        chk_irq(1'b1, "R7 pin re-asserts");

        // R9 reset mid-run
        @(posedge clk); #1 rst = 1'b1;
        idle(2);
        rst = 1'b0;
        chk_irq(1'b0, "R9 irq low after reset");
        chk_rd(SEL_T_EN, 32'h0, "R9 top enable cleared");
        chk_rd(SEL_T_STAT, 32'h0, "R9 top status cleared");
        chk_rd(SEL_CFG, 32'h0, "R9 pin enable cleared");

        idle(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule